// File: doc/BRIEF.md
# GPIO Companion Register Controller

This block is a small register-mapped controller for a 16-bit companion device. A host reaches it over a plain synchronous bus: address, write strobe, write data, read strobe and registered read data. Behind the bus sit several 16-bit control words (mode, clock divider, power, clock control and three interrupt-related words, all plain storage here), a fixed status word, and a bank of 16 general-purpose lines.

The line bank keeps one level word that two agents share. The host writes it through either of two offsets, and each write is masked by the direction word. External input pins also change it, bit by bit, whenever a pin changes value, with no masking. The 16 output pins carry level AND direction. They are registered and move only on the cycle after the host writes the direction or level word. An input change alone leaves the pins alone until the next such write.

Address decoding looks only at the low six address bits, so the register set repeats every 64 bytes. The power word has a set rule: when written data has bit 7 set, bits 15 and 6 are forced on as well.

Top module: `gpio_companion`

## Requirements
- R1: After synchronous active-high reset, every stored word reads 0x0000 except the status word, which reads 0x0002. `gpio_out` and `bus_rdata` are 0.
- R2: Only `bus_addr[5:0]` is decoded. Register offsets: mode 0x00, clock divider 0x04, status 0x08, power 0x0C, clock control 0x10, interrupt raw 0x14, interrupt mask 0x18, interrupt status 0x1C, direction 0x20, level write 0x24, level read 0x28. Any upper address bits select the same register.
- R3: A write to the mode, clock divider, clock control or any of the three interrupt words stores `bus_wdata[15:0]` and drops bits 31:16.
- R4: A power write stores `bus_wdata[15:0]`. When bit 7 of that data is 1, bits 15 and 6 of the stored value are also 1.
- R5: A write to offset 0x24 or 0x28 stores `bus_wdata[15:0]` AND the current direction word into the level word.
- R6: A read of 0x24 or 0x28 returns the level word. A read of 0x20 returns the direction word.
- R7: `gpio_out` becomes level AND direction one cycle after the edge that accepts a direction or level write, and it holds its value in every other cycle.
- R8: When `gpio_in[n]` differs from its value at the previous edge, level bit n takes the new pin value, whatever the direction. This wins over a host level write in the same cycle and does not change `gpio_out` by itself.
- R9: The status word is read-only. A write to 0x08 changes nothing.
- R10: A read from an unmapped offset (0x2C to 0x3F, or any offset that is not a multiple of 4) returns 0. A write there changes no register.
- R11: `bus_rdata` is updated at the edge where `bus_re` is sampled high and holds its value while `bus_re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address; low 6 bits decoded |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data; low 16 bits used |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| gpio_in | input | 16 | External input lines feeding the level word |
| gpio_out | output | 16 | Registered level AND direction |

## Verification
The line bank is tried with three kinds of pattern. Host level writes under partial direction masks separate the masked store from an unmasked one. Input pin toggles on lines whose direction bit is 0 show the unmasked pin path into the level word and show that the pins stay still. A pin change landing in the same cycle as a host level write shows which source has priority. Random traffic over aliased, misaligned and unmapped addresses, checked against a bench model, separates correct six-bit decoding from wider or narrower decoding, and catches stray writes into neighbouring words.

// File: rtl/gpc_pkg.sv
package gpc_pkg;

    localparam int DEC_W = 6;

    localparam logic [DEC_W-1:0] OFF_MODE    = 6'h00;
    localparam logic [DEC_W-1:0] OFF_CLKDIV  = 6'h04;
    localparam logic [DEC_W-1:0] OFF_STATUS  = 6'h08;
    localparam logic [DEC_W-1:0] OFF_POWER   = 6'h0C;
    localparam logic [DEC_W-1:0] OFF_CLKCTL  = 6'h10;
    localparam logic [DEC_W-1:0] OFF_IRQRAW  = 6'h14;
    localparam logic [DEC_W-1:0] OFF_IRQMASK = 6'h18;
    localparam logic [DEC_W-1:0] OFF_IRQSTAT = 6'h1C;
    localparam logic [DEC_W-1:0] OFF_DIR     = 6'h20;
    localparam logic [DEC_W-1:0] OFF_LVLW    = 6'h24;
    localparam logic [DEC_W-1:0] OFF_LVLR    = 6'h28;

    typedef enum logic [3:0] {
        SEL_MODE,
        SEL_CLKDIV,
        SEL_STATUS,
        SEL_POWER,
        SEL_CLKCTL,
        SEL_IRQRAW,
        SEL_IRQMASK,
        SEL_IRQSTAT,
        SEL_DIR,
        SEL_LVLW,
        SEL_LVLR,
        SEL_NONE
    } reg_sel_e;

endpackage

// File: rtl/gpc_addr_decode.sv
module gpc_addr_decode
    import gpc_pkg::*;
(
    input  logic [DEC_W-1:0] offset,
    output reg_sel_e         sel
);

    always_comb begin
        unique case (offset)
            OFF_MODE:    sel = SEL_MODE;
            OFF_CLKDIV:  sel = SEL_CLKDIV;
            OFF_STATUS:  sel = SEL_STATUS;
            OFF_POWER:   sel = SEL_POWER;
            OFF_CLKCTL:  sel = SEL_CLKCTL;
            OFF_IRQRAW:  sel = SEL_IRQRAW;
            OFF_IRQMASK: sel = SEL_IRQMASK;
            OFF_IRQSTAT: sel = SEL_IRQSTAT;
            OFF_DIR:     sel = SEL_DIR;
            OFF_LVLW:    sel = SEL_LVLW;
            OFF_LVLR:    sel = SEL_LVLR;
            default:     sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/gpc_ctrl_regs.sv
module gpc_ctrl_regs
    import gpc_pkg::*;
#(
    parameter int               DATA_W       = 16,
    parameter int               PWR_TRIG_BIT = 7,
    parameter logic [DATA_W-1:0] PWR_SET_MASK = 16'h8040,
    parameter logic [DATA_W-1:0] STATUS_RST   = 16'h0002
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mode_q,
    output logic [DATA_W-1:0] clkdiv_q,
    output logic [DATA_W-1:0] status_q,
    output logic [DATA_W-1:0] power_q,
    output logic [DATA_W-1:0] clkctl_q,
    output logic [DATA_W-1:0] irqraw_q,
    output logic [DATA_W-1:0] irqmask_q,
    output logic [DATA_W-1:0] irqstat_q
);

    logic [DATA_W-1:0] power_next;

    assign status_q   = STATUS_RST;
    assign power_next = wdata | (wdata[PWR_TRIG_BIT] ? PWR_SET_MASK : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= '0;
            clkdiv_q  <= '0;
            power_q   <= '0;
            clkctl_q  <= '0;
            irqraw_q  <= '0;
            irqmask_q <= '0;
            irqstat_q <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_MODE:    mode_q    <= wdata;
                SEL_CLKDIV:  clkdiv_q  <= wdata;
                SEL_POWER:   power_q   <= power_next;
                SEL_CLKCTL:  clkctl_q  <= wdata;
                SEL_IRQRAW:  irqraw_q  <= wdata;
                SEL_IRQMASK: irqmask_q <= wdata;
                SEL_IRQSTAT: irqstat_q <= wdata;
                default:     ;
            endcase
        end
    end

    AST_POWER_FORCE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_POWER && wdata[PWR_TRIG_BIT])
        |=> ((power_q & PWR_SET_MASK) == PWR_SET_MASK)); // R4

    AST_MODE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && sel == SEL_MODE) |=> $stable(mode_q)); // R10

endmodule

// File: rtl/gpc_gpio_bank.sv
module gpc_gpio_bank #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dir_wr,
    input  logic             lvl_wr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] lvl_q,
    output logic [WIDTH-1:0] pin_out
);

    logic [WIDTH-1:0] pin_prev;
    logic [WIDTH-1:0] pin_chg;
    logic             upd_q;

    assign pin_chg = pin_in ^ pin_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q    <= '0;
            pin_prev <= '0;
            upd_q    <= 1'b0;
            pin_out  <= '0;
        end else begin
            pin_prev <= pin_in;
            upd_q    <= dir_wr | lvl_wr;
            if (dir_wr) begin
                dir_q <= wdata;
            end
            if (upd_q) begin
                pin_out <= lvl_q & dir_q;
            end
        end
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                lvl_q[i] <= 1'b0;
            end else if (pin_chg[i]) begin
                lvl_q[i] <= pin_in[i];
            end else if (lvl_wr) begin
                lvl_q[i] <= wdata[i] & dir_q[i];
            end
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !upd_q |=> $stable(pin_out)); // R7

    AST_LVL_MASKED: assert property (@(posedge clk) disable iff (rst)
        (lvl_wr && pin_chg == '0) |=> ((lvl_q & ~$past(dir_q)) == '0)); // R5

    AST_PIN_DIRECT: assert property (@(posedge clk) disable iff (rst)
        (pin_chg != '0) |=> (((lvl_q ^ $past(pin_in)) & $past(pin_chg)) == '0)); // R8

endmodule

// File: rtl/gpio_companion.sv
module gpio_companion
    import gpc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BUS_W  = 32,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] gpio_in,
    output logic [DATA_W-1:0] gpio_out
);

    localparam int LINES = DATA_W;

    reg_sel_e          sel;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rd_val;
    logic [DATA_W-1:0] mode_q, clkdiv_q, status_q, power_q;
    logic [DATA_W-1:0] clkctl_q, irqraw_q, irqmask_q, irqstat_q;
    logic [LINES-1:0]  dir_q, lvl_q;
    logic              dir_wr, lvl_wr;
    logic              unused_hi;

    assign wdata     = bus_wdata[DATA_W-1:0];
    assign unused_hi = ^{bus_wdata[BUS_W-1:DATA_W], bus_addr[ADDR_W-1:DEC_W]};
    assign dir_wr    = bus_we && (sel == SEL_DIR);
    assign lvl_wr    = bus_we && (sel == SEL_LVLW || sel == SEL_LVLR);

    gpc_addr_decode u_decode (
        .offset (bus_addr[DEC_W-1:0]),
        .sel    (sel)
    );

    gpc_ctrl_regs #(
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bus_we),
        .sel       (sel),
        .wdata     (wdata),
        .mode_q    (mode_q),
        .clkdiv_q  (clkdiv_q),
        .status_q  (status_q),
        .power_q   (power_q),
        .clkctl_q  (clkctl_q),
        .irqraw_q  (irqraw_q),
        .irqmask_q (irqmask_q),
        .irqstat_q (irqstat_q)
    );

    gpc_gpio_bank #(
        .WIDTH (LINES)
    ) u_gpio (
        .clk     (clk),
        .rst     (rst),
        .dir_wr  (dir_wr),
        .lvl_wr  (lvl_wr),
        .wdata   (wdata),
        .pin_in  (gpio_in),
        .dir_q   (dir_q),
        .lvl_q   (lvl_q),
        .pin_out (gpio_out)
    );

    always_comb begin
        unique case (sel)
            SEL_MODE:           rd_val = mode_q;
            SEL_CLKDIV:         rd_val = clkdiv_q;
            SEL_STATUS:         rd_val = status_q;
            SEL_POWER:          rd_val = power_q;
            SEL_CLKCTL:         rd_val = clkctl_q;
            SEL_IRQRAW:         rd_val = irqraw_q;
            SEL_IRQMASK:        rd_val = irqmask_q;
            SEL_IRQSTAT:        rd_val = irqstat_q;
            SEL_DIR:            rd_val = dir_q;
            SEL_LVLW, SEL_LVLR: rd_val = lvl_q;
            default:            rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_re) begin
            bus_rdata <= rd_val;
        end
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_re && sel == SEL_NONE) |=> (bus_rdata == '0)); // R10

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> $stable(bus_rdata)); // R11

    AST_LEVEL_ALIAS: assert property (@(posedge clk) disable iff (rst)
        (bus_re && (sel == SEL_LVLW || sel == SEL_LVLR)) |=> (bus_rdata == $past(lvl_q))); // R6

endmodule

// File: tb/gpio_companion_bench.sv
module gpio_companion_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [15:0] bus_rdata;
    logic [15:0] gpio_in = '0;
    logic [15:0] gpio_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [15:0] m_mode, m_cdiv, m_pwr, m_cctl, m_iraw, m_imsk, m_ista;
    logic [15:0] m_dir, m_lvl, m_out, m_pin;

    always #5 clk = ~clk;

    gpio_companion u_gpio_companion (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .gpio_in   (gpio_in),
        .gpio_out  (gpio_out)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=0x%04h exp=0x%04h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [5:0] off);
        case (off)
            6'h00:        return m_mode;
            6'h04:        return m_cdiv;
            6'h08:        return 16'h0002;
            6'h0C:        return m_pwr;
            6'h10:        return m_cctl;
            6'h14:        return m_iraw;
            6'h18:        return m_imsk;
            6'h1C:        return m_ista;
            6'h20:        return m_dir;
            6'h24, 6'h28: return m_lvl;
            default:      return 16'h0000;
        endcase
    endfunction

    task automatic model_write(input logic [5:0] off, input logic [31:0] d);
        logic [15:0] v;
        v = d[15:0];
        case (off)
            6'h00: m_mode = v;
            6'h04: m_cdiv = v;
            6'h0C: m_pwr  = v[7] ? (v | 16'h8040) : v;
            6'h10: m_cctl = v;
            6'h14: m_iraw = v;
            6'h18: m_imsk = v;
            6'h1C: m_ista = v;
            6'h20: begin m_dir = v; m_out = m_lvl & m_dir; end
            6'h24, 6'h28: begin m_lvl = v & m_dir; m_out = m_lvl & m_dir; end
            default: ;
        endcase
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        model_write(a[5:0], d);
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [15:0] r);
        @(negedge clk);
        bus_addr = a;
        bus_re   = 1'b1;
        @(negedge clk);
        bus_re   = 1'b0;
        r = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a);
        logic [15:0] r;
        bus_rd(a, r);
        chk(req, r, exp_read(a[5:0]));
    endtask

    task automatic set_pins(input logic [15:0] v);
        @(negedge clk);
        gpio_in = v;
        @(negedge clk);
        m_lvl = (m_lvl & ~(v ^ m_pin)) | (v & (v ^ m_pin));
        m_pin = v;
    endtask

    task automatic idle_chk_out(input string req);
        @(negedge clk);
        chk(req, gpio_out, m_out);
    endtask

    function automatic logic [11:0] rand_addr();
        int r;
        logic [5:0] low;
        r = $urandom_range(0, 13);
        if (r <= 10) low = 6'(r * 4);
        else if (r == 11) low = 6'(8'h2C + 4 * $urandom_range(0, 4));
        else low = 6'($urandom_range(0, 10) * 4 + $urandom_range(1, 3));
        return {6'($urandom_range(0, 63)), low};
    endfunction

    initial begin
        logic [15:0] r;
        logic [15:0] hold;
        void'($urandom(32'h5EED));
        m_mode = '0; m_cdiv = '0; m_pwr = '0; m_cctl = '0; m_iraw = '0;
        m_imsk = '0; m_ista = '0; m_dir = '0; m_lvl = '0; m_out = '0; m_pin = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 rdata", bus_rdata, 16'h0000);
        chk("R1 gpio_out", gpio_out, 16'h0000);
        for (int i = 0; i < 11; i++) rd_chk("R1 reset read", 12'(i * 4));

        // R2: aliasing through upper address bits
        bus_wr(12'hA40, 32'h0000_5A5A);
        rd_chk("R2 alias mode", 12'h000);
        rd_chk("R2 alias mode hi", 12'hFC0);

        // R3: upper data bits dropped
        bus_wr(12'h004, 32'hABCD_1234);
        rd_chk("R3 clkdiv", 12'h004);
        bus_wr(12'h018, 32'hFFFF_00F0);
        rd_chk("R3 irqmask", 12'h018);

        // R4: power set rule
        bus_wr(12'h00C, 32'h0000_0080);
        bus_rd(12'h00C, r);
        chk("R4 power bit7", r, 16'h80C0);
        bus_wr(12'h00C, 32'h0000_0101);
        bus_rd(12'h00C, r);
        chk("R4 power no bit7", r, 16'h0101);

        // R5/R6/R7: masked level write and output timing
        bus_wr(12'h020, 32'h0000_00FF);
        idle_chk_out("R7 after dir");
        bus_wr(12'h028, 32'h0000_FFFF);
        chk("R7 not yet", gpio_out, 16'h0000);
        @(negedge clk);
        chk("R7 next cycle", gpio_out, 16'h00FF);
        bus_rd(12'h024, r);
        chk("R5 masked level", r, 16'h00FF);
        rd_chk("R6 level via 0x28", 12'h028);
        rd_chk("R6 dir", 12'h020);

        // R8: input on an input-direction line, no output change
        set_pins(16'h1000);
        chk("R8 pins hold", gpio_out, 16'h00FF);
        rd_chk("R8 level from pin", 12'h024);
        bus_wr(12'h020, 32'h0000_FFFF);
        idle_chk_out("R8 visible after dir write");

        // R8: pin change wins over same-cycle level write
        @(negedge clk);
        gpio_in   = 16'h1008;
        bus_addr  = 12'h024;
        bus_wdata = 32'h0000_0000;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        m_lvl = 16'h0008;
        m_pin = 16'h1008;
        m_out = m_lvl & m_dir;
        bus_rd(12'h024, r);
        chk("R8 pin priority", r, 16'h0008);

        // R9/R10: ignored writes, zero reads
        bus_wr(12'h008, 32'h0000_FFFF);
        rd_chk("R9 status", 12'h008);
        bus_wr(12'h02C, 32'h0000_FFFF);
        bus_wr(12'h001, 32'h0000_FFFF);
        for (int i = 0; i < 11; i++) rd_chk("R10 no stray write", 12'(i * 4));
        bus_rd(12'h030, r);
        chk("R10 unmapped read", r, 16'h0000);
        bus_rd(12'h021, r);
        chk("R10 misaligned read", r, 16'h0000);

        // R11: read data holds while bus_re low
        hold = bus_rdata;
        bus_wr(12'h000, 32'h0000_1111);
        @(negedge clk);
        chk("R11 hold", bus_rdata, hold);

        // Random traffic
        for (int n = 0; n < 400; n++) begin
            int op;
            logic [11:0] a;
            op = $urandom_range(0, 9);
            a  = rand_addr();
            if (op <= 3) begin
                bus_wr(a, $urandom());
                idle_chk_out("R7 random out");
            end else if (op <= 7) begin
                rd_chk("R2 random read", a);
            end else begin
                set_pins(16'($urandom()));
                chk("R8 random pins hold", gpio_out, m_out);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule